// File: doc/BRIEF.md
# Periodic Wake-up Countdown Timer

This block is a reloading 24-bit down counter that marks a fixed, repeating interval. Each time the count runs out it sets a sticky timer flag, reloads the programmed preset and carries on counting. If the interrupt enable is set, it also drives an active-low interrupt line low. The line then returns high by itself after a short time that depends on the selected source clock. The counter advances on one of four tick enables: a 4096 Hz base tick, or one of three slower pre-divided ticks at 64 Hz, 1 Hz and one per minute.

Software programs the block through a small byte-wide register port. Three registers hold the preset, one holds the control bits, and one holds the flag. While the timer is stopped, a read of the preset registers returns the stored preset, and those registers serve as plain storage. While the timer runs, the same reads return the live count. The count is not latched, so software reads it twice and compares the results. Counting starts on the first selected tick after enabling, with no alignment step. The first interval can therefore be up to one tick short.

Top module: `wakeTimer`

## Requirements
- R1: Register addresses 0, 1 and 2 hold preset bits 7:0, 15:8 and 23:16, least significant byte first. While the enable bit is 0, writes to them are stored and reads return them, so they act as plain read/write storage.
- R2: Address 3 is the control register: bit 0 is the timer enable, bit 1 is the interrupt enable and bits 3:2 are the source select. Its other bits read as 0. Source select 00 counts on baseTick, 01 on tick64, 10 on tick1s and 11 on tick1m; ticks of the other sources do not move the count.
- R3: While the enable bit is 1, reads of addresses 0 to 2 return the matching byte of the live count.
- R4: A preset of N expires on the Nth selected tick. On expiry the flag (address 4, bit 0) is set and the count reloads to N, and the cycle repeats.
- R5: A preset of 000000h gives a period of 2^24 ticks: the first tick after enabling takes the count to FFFFFFh and does not expire.
- R6: The flag is set on every expiry. irqN goes low on an expiry only when the interrupt enable is 1.
- R7: irqN returns high on its own. With source 00 this happens on the first baseTick after the expiry; with any other source it happens on the 32nd baseTick after the expiry.
- R8: Writing a value with bit 0 equal to 0 to address 4 clears the flag. Writing 1 to that bit leaves the flag unchanged.
- R9: While the enable bit is 1, writes to the preset registers and to the source select are ignored. The enable and interrupt-enable bits stay writable.
- R10: The count does not wait for a tick boundary when the timer is enabled. The first selected tick after the enabling write decrements it.
- R11: After reset, all registers read 0 and irqN is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle 4096 Hz enable |
| tick64 | input | 1 | One-cycle 64 Hz enable |
| tick1s | input | 1 | One-cycle 1 Hz enable |
| tick1m | input | 1 | One-cycle once-per-minute enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irqN | output | 1 | Active-low interrupt, self-clearing |

## Verification
The hardest behaviour to reach is the auto-return of irqN for the slow sources. It needs an expiry on a slow tick, followed by a count of base ticks that must not disturb the running count. The bench uses a preset of 1 so that one tick64 pulse forces the expiry. It then feeds exactly 31 base ticks and checks that the line is still low, and checks that the 32nd tick releases it. A second hard case is the locked preset, which can only be seen after the timer stops again. The bench writes while the timer runs, disables it, and then reads the registers back.

// File: rtl/wakeTimerPkg.sv
package wakeTimerPkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] ADDR_CNT0 = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_CNT1 = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CNT2 = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_FLAG = 3'd4;

  typedef enum logic [1:0] {
    SRC_4096HZ = 2'b00,
    SRC_64HZ   = 2'b01,
    SRC_1HZ    = 2'b10,
    SRC_1MIN   = 2'b11
  } srcSel_t;

  typedef struct packed {
    logic load;  // follow the preset while stopped
    logic step;  // selected tick while running
  } ctrlStrobes_t;
endpackage

// File: rtl/wakeTimerDatapath.sv
module wakeTimerDatapath
  import wakeTimerPkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             atOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign atOne = (count == ONE);

  // A zero preset wraps through all ones, so the period is 2^CNT_W ticks
  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (strobes.load)  count <= preset;
    else if (strobes.step)  count <= atOne ? preset : count - ONE;
  end

  // R10: the count moves only on a load or on a selected tick
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(count));
  // R4: an expiring tick reloads the preset
  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load && atOne) |=> (count == $past(preset)));
endmodule

// File: rtl/wakeTimerCtrl.sv
module wakeTimerCtrl
  import wakeTimerPkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int RET_SHORT = 1,
  parameter int RET_LONG  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              tick64,
  input  logic              tick1s,
  input  logic              tick1m,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              atOne,
  output ctrlStrobes_t      strobes,
  output logic [CNT_W-1:0]  preset,
  output logic              enable,
  output logic              irqEn,
  output srcSel_t           srcSel,
  output logic              tfFlag,
  output logic              irqN
);
  localparam int RET_W = $clog2(RET_LONG + 1);
  localparam int NBYTES = CNT_W / 8;

  logic             selTick;
  logic             expire;
  logic             irqActive;
  logic [RET_W-1:0] retCnt;

  always_comb begin
    case (srcSel)
      SRC_4096HZ: selTick = baseTick;
      SRC_64HZ:   selTick = tick64;
      SRC_1HZ:    selTick = tick1s;
      default:    selTick = tick1m;
    endcase
  end

  assign strobes.load = !enable;
  assign strobes.step = enable && selTick;
  assign expire       = strobes.step && atOne;
  assign irqN         = !irqActive;

  // Preset bytes, writable only while stopped
  for (genvar b = 0; b < NBYTES; b++) begin : g_presetByte
    always_ff @(posedge clk) begin
      if (!rstN) preset[8*b +: 8] <= '0;
      else if (regWe && !enable && regAddr == REG_AW'(b))
        preset[8*b +: 8] <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      irqEn  <= 1'b0;
      srcSel <= SRC_4096HZ;
      tfFlag <= 1'b0;
    end else begin
      if (regWe && regAddr == ADDR_CTRL) begin
        enable <= regWdata[0];
        irqEn  <= regWdata[1];
        if (!enable) srcSel <= srcSel_t'(regWdata[3:2]);
      end
      if (expire)
        tfFlag <= 1'b1;
      else if (regWe && regAddr == ADDR_FLAG && !regWdata[0])
        tfFlag <= 1'b0;
    end
  end

  // Self-clearing interrupt, timed in base ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqActive <= 1'b0;
      retCnt    <= '0;
    end else if (expire && irqEn) begin
      irqActive <= 1'b1;
      retCnt    <= (srcSel == SRC_4096HZ) ? RET_W'(RET_SHORT) : RET_W'(RET_LONG);
    end else if (irqActive && baseTick) begin
      if (retCnt == RET_W'(1)) irqActive <= 1'b0;
      else                     retCnt    <= retCnt - RET_W'(1);
    end
  end

  p_tf_on_expire_r4: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> tfFlag);
  p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(expire && irqEn));
  p_preset_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) |-> $stable(preset));
  p_src_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) |-> $stable(srcSel));
  p_irq_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |-> $past(baseTick));
endmodule

// File: rtl/wakeTimer.sv
module wakeTimer
  import wakeTimerPkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int RET_SHORT = 1,
  parameter int RET_LONG  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       tick64,
  input  logic       tick1s,
  input  logic       tick1m,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irqN
);
  localparam int NBYTES = CNT_W / 8;

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] preset;
  logic [CNT_W-1:0] count;
  logic             atOne;
  logic             enable;
  logic             irqEn;
  srcSel_t          srcSel;
  logic             tfFlag;
  logic [CNT_W-1:0] viewWord;

  wakeTimerCtrl #(.CNT_W(CNT_W), .RET_SHORT(RET_SHORT), .RET_LONG(RET_LONG)) uCtrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .tick64(tick64),
    .tick1s(tick1s), .tick1m(tick1m), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .atOne(atOne), .strobes(strobes), .preset(preset),
    .enable(enable), .irqEn(irqEn), .srcSel(srcSel), .tfFlag(tfFlag),
    .irqN(irqN)
  );

  wakeTimerDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .preset(preset),
    .count(count), .atOne(atOne)
  );

  assign viewWord = enable ? count : preset;

  always_comb begin
    regRdata = '0;
    for (int b = 0; b < NBYTES; b++)
      if (regAddr == REG_AW'(b)) regRdata = viewWord[8*b +: 8];
    if (regAddr == ADDR_CTRL) regRdata = {4'b0, srcSel, irqEn, enable};
    if (regAddr == ADDR_FLAG) regRdata = {7'b0, tfFlag};
  end
endmodule

// File: tb/tb_wakeTimer.sv
module tb_wakeTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0, tick64 = 1'b0, tick1s = 1'b0, tick1m = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       irqN;
  int checks = 0, failures = 0;
  bit finished = 0;

  wakeTimer dut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic rdWord(output logic [23:0] w);
    logic [7:0] b0, b1, b2;
    rd(0, b0); rd(1, b1); rd(2, b2);
    w = {b2, b1, b0};
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which) 0: baseTick = 1; 1: tick64 = 1; 2: tick1s = 1; default: tick1m = 1; endcase
      @(negedge clk);
      baseTick = 0; tick64 = 0; tick1s = 0; tick1m = 0;
    end
  endtask

  task automatic setPreset(input logic [23:0] p);
    wr(0, p[7:0]); wr(1, p[15:8]); wr(2, p[23:16]);
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); check("R11 reg", d, 0); end
    check("R11 irqN", irqN, 1);
  endtask

  task automatic testStorage();
    logic [23:0] w; logic [7:0] d;
    setPreset(24'hA5C312);
    rdWord(w); check("R1 preset readback", w, 24'hA5C312);
    wr(3, 8'h0E); rd(3, d); check("R2 ctrl fields", d, 8'h0E);
    wr(3, 8'h00);
  endtask

  task automatic testPeriodic();
    logic [23:0] w; logic [7:0] d;
    wr(4, 0); setPreset(24'd3); wr(3, 8'h03);            // src 00, irqEn, enable
    pulse(0, 1); rdWord(w); check("R10 first tick decrements", w, 2);
    pulse(1, 2); rdWord(w); check("R2 other source ignored", w, 2);
    pulse(0, 1); rdWord(w); check("R3 live count", w, 1);
    pulse(0, 1);
    rd(4, d); check("R4 flag on expiry", d, 1);
    check("R6 irq low", irqN, 0);
    rdWord(w); check("R4 reload", w, 3);
    pulse(0, 1); check("R7 short release", irqN, 1);
    wr(4, 8'h01); rd(4, d); check("R8 write 1 keeps flag", d, 1);
    wr(4, 8'h00); rd(4, d); check("R8 write 0 clears flag", d, 0);
    pulse(0, 2); rd(4, d); check("R4 repeats", d, 1);
    wr(3, 8'h00); wr(4, 0);
  endtask

  task automatic testNoIrq();
    logic [7:0] d;
    setPreset(24'd1); wr(3, 8'h01);
    pulse(0, 1); rd(4, d); check("R6 flag without irqEn", d, 1);
    check("R6 irq stays high", irqN, 1);
    wr(3, 8'h00); wr(4, 0);
  endtask

  task automatic testLongRelease();
    setPreset(24'd1); wr(3, 8'h07);                       // src 01, irqEn, enable
    pulse(1, 1); check("R7 long assert", irqN, 0);
    pulse(0, 31); check("R7 low after 31", irqN, 0);
    pulse(0, 1); check("R7 release at 32", irqN, 1);
    wr(3, 8'h04); wr(4, 0);
  endtask

  task automatic testLocked();
    logic [23:0] w; logic [7:0] d;
    setPreset(24'd10); wr(3, 8'h05);                      // src 01 running
    wr(0, 8'h55); wr(3, 8'h09);                           // try src 10, keep enable
    rd(3, d); check("R9 src locked", d[3:2], 2'b01);
    pulse(2, 1); rdWord(w); check("R9 1Hz ignored", w, 10);
    pulse(1, 1); rdWord(w); check("R9 64Hz counts", w, 9);
    wr(3, 8'h00); rdWord(w); check("R9 preset kept", w, 10);
  endtask

  task automatic testZero();
    logic [23:0] w; logic [7:0] d;
    setPreset(24'd0); wr(3, 8'h0D);                       // src 11 running
    pulse(3, 1); rdWord(w); check("R5 wraps to max", w, 24'hFFFFFF);
    rd(4, d); check("R5 no expiry", d, 0);
    wr(3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testStorage();
    testPeriodic();
    testNoIrq();
    testLongRelease();
    testLocked();
    testZero();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule